// File: doc/BRIEF.md
# Four-Way Fetch Cache with Most-Recent-Way Exclusion

This block is a read-only, four-way set-associative cache for an instruction fetch path. A requester presents a word address. The cache splits it into a tag, a set index and a word select. It reads the tags, valid bits and blocks of all four ways of the indexed set at the same time and compares every tag in parallel. The block from the matching way passes through a way multiplexer, and the addressed word is returned one cycle after the request was taken.

On a miss the cache raises `busy` and asks the next level for the whole block, giving a block address. The block arrives in a single transfer. It is written into a chosen way, and the requested word is returned in the same cycle.

Each set remembers only the way it used most recently. A hit or a refill updates this record. When the set has an empty way, the refill goes into the lowest-numbered empty way. Otherwise a free-running 8-bit LFSR picks a way. If that pick is the most recent way, it moves to the next way up, modulo four, so the most recent way is never evicted.

Top module: `assoc4_fetch_cache`

## Requirements
- R1: After reset `busy`, `resp_valid` and `mem_req` are low, and every line is invalid, so the first access to any address misses.
- R2: A request taken while `busy` is low that matches a valid line gives `resp_valid=1` and `resp_hit=1` in the next cycle. `resp_data` is the word selected by word address bits [WSEL_W-1:0] (word k sits at block bits [32k+31:32k]).
- R3: A miss drives `busy` high in the cycle after the request. `mem_req` then stays high with a steady `mem_addr`, equal to the request's word address shifted right by WSEL_W, until `mem_valid` arrives.
- R4: In the cycle `mem_valid` is high during a refill, the cache gives `resp_valid=1`, `resp_hit=0` and the requested word taken from `mem_data`. Afterwards the block hits.
- R5: While a set has an invalid way, a refill fills an invalid way, so four distinct blocks mapping to one set all stay resident.
- R6: When all four ways are valid, the victim is never the way most recently hit or refilled in that set.
- R7: Misses in one set never disturb the contents of another set.
- R8: `busy` stays low in a hit cycle, so a new request can be taken in that cycle and answered in the next, giving one hit per cycle.
- R9: At most one way matches a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_addr | input | ADDR_W | Word address of the request |
| busy | output | 1 | Miss in progress; requests are not taken |
| resp_valid | output | 1 | Response word valid this cycle |
| resp_hit | output | 1 | Response came from a hit (0 on a refill response) |
| resp_data | output | WORD_W | Requested word |
| mem_req | output | 1 | Block request to the next level |
| mem_addr | output | ADDR_W-WSEL_W | Block address requested |
| mem_valid | input | 1 | Block transfer present this cycle |
| mem_data | input | WORD_W*BLK_WORDS | Whole block, word 0 in the low bits |

## Verification
The bench builds the cache with 16-bit word addresses, four words per block and only four sets. Blocks that differ by 16 word addresses therefore alias onto one set, so a few accesses fill a set completely and force evictions. Repeated rounds on one full set each make a fresh miss right after touching a known most-recent line. The line touched must still hit afterwards, and this is checked under LFSR picks that vary from round to round. Memory latency changes between zero and several cycles, so refill responses arrive in different cycles.

// File: rtl/assoc4_fetch_cache.sv
module assoc4_fetch_cache #(
  parameter int ADDR_W    = 30,
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 4,
  parameter int SETS      = 16,
  parameter logic [7:0] LFSR_SEED = 8'hB5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [ADDR_W-1:0]           req_addr,
  output logic                        busy,
  output logic                        resp_valid,
  output logic                        resp_hit,
  output logic [WORD_W-1:0]           resp_data,
  output logic                        mem_req,
  output logic [ADDR_W-$clog2(BLK_WORDS)-1:0] mem_addr,
  input  logic                        mem_valid,
  input  logic [WORD_W*BLK_WORDS-1:0] mem_data
);
  localparam int WAYS   = 4;
  localparam int WSEL_W = $clog2(BLK_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - WSEL_W - IDX_W;
  localparam int BLK_W  = WORD_W * BLK_WORDS;

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [BLK_W-1:0] dat_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [1:0]       mru_q [SETS];
  logic             look_q, fill_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]       vic_q;
  logic [7:0]       lfsr_q;

  wire [IDX_W-1:0]  idx  = addr_q[WSEL_W +: IDX_W];
  wire [TAG_W-1:0]  tag  = addr_q[ADDR_W-1 -: TAG_W];
  wire [WSEL_W-1:0] wsel = addr_q[WSEL_W-1:0];

  logic [WAYS-1:0]  hit_vec;
  logic [1:0]       hit_way;
  logic [BLK_W-1:0] hit_blk;

  always_comb begin
    hit_way = 2'd0;
    hit_blk = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld_q[idx][w] && (tag_q[idx][w] == tag);
      if (hit_vec[w]) begin
        hit_way = 2'(w);
        hit_blk = dat_q[idx][w];
      end
    end
  end

  logic [1:0] rnd, vic;
  always_comb begin
    rnd = lfsr_q[1:0];
    vic = (rnd == mru_q[idx]) ? rnd + 2'd1 : rnd;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_q[idx][w]) vic = 2'(w);
  end

  wire hit  = look_q && (|hit_vec);
  wire miss = look_q && !(|hit_vec);
  wire done = fill_q && mem_valid;
  wire take = req_valid && !busy;

  assign busy       = fill_q || miss;
  assign mem_req    = fill_q;
  assign mem_addr   = addr_q[ADDR_W-1:WSEL_W];
  assign resp_valid = hit || done;
  assign resp_hit   = hit;

  wire [BLK_W-1:0] out_blk = done ? mem_data : hit_blk;
  assign resp_data = out_blk[wsel*WORD_W +: WORD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      look_q <= 1'b0;
      fill_q <= 1'b0;
      addr_q <= '0;
      vic_q  <= 2'd0;
      lfsr_q <= LFSR_SEED;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        mru_q[s] <= 2'd0;
      end
    end else begin
      lfsr_q <= {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
      look_q <= take;
      if (take) addr_q <= req_addr;
      if (miss) begin
        fill_q <= 1'b1;
        vic_q  <= vic;
      end
      if (hit) mru_q[idx] <= hit_way;
      if (done) begin
        fill_q <= 1'b0;
        vld_q[idx][vic_q] <= 1'b1;
        mru_q[idx] <= vic_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (done) begin
      tag_q[idx][vic_q] <= tag;
      dat_q[idx][vic_q] <= mem_data;
    end
  end

  // R9
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    look_q |-> $onehot0(hit_vec));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R6
  vic_not_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && (&vld_q[idx])) |-> (vic != mru_q[idx]));

  // R5
  vic_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !(&vld_q[idx])) |-> !vld_q[idx][vic]);

  // R4
  fill_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (vld_q[$past(idx)][$past(vic_q)] && (mru_q[$past(idx)] == $past(vic_q))));

  // R8
  hit_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |-> !busy);
endmodule

// File: tb/assoc4_fetch_cache_tb.sv
module assoc4_fetch_cache_tb;
  localparam int AW = 16, WW = 32, BW = 4, NS = 4;
  localparam int BLKW = WW * BW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic busy, resp_valid, resp_hit, mem_req;
  logic [WW-1:0] resp_data;
  logic [AW-3:0] mem_addr;
  logic mem_valid = 1'b0;
  logic [BLKW-1:0] mem_data = '0;

  int errors = 0, checks = 0, lat = 1;

  always #5 clk = ~clk;

  assoc4_fetch_cache #(.ADDR_W(AW), .WORD_W(WW), .BLK_WORDS(BW), .SETS(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data));

  function automatic logic [WW-1:0] word_of(input logic [AW-1:0] wa);
    return (32'(wa) * 32'h0001_9E37) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [BLKW-1:0] blk_of(input logic [AW-3:0] ba);
    logic [BLKW-1:0] b;
    for (int i = 0; i < BW; i++) b[i*WW +: WW] = word_of({ba, 2'(i)});
    return b;
  endfunction

  function automatic logic [AW-1:0] adr(input int set, input int tg, input int w);
    return {12'(tg), 2'(set), 2'(w)};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    if (mem_req && !mem_valid) begin
      repeat (lat) @(negedge clk);
      mem_data  = blk_of(mem_addr);
      mem_valid = 1'b1;
      @(negedge clk);
      mem_valid = 1'b0;
    end
  end

  task automatic access(input logic [AW-1:0] a, input bit exp_hit, input string rq);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    if (exp_hit) begin
      chk(resp_valid && resp_hit, rq, "hit in next cycle", {30'd0, resp_valid, resp_hit}, 32'd3);
      chk(resp_data == word_of(a), rq, "hit word", resp_data, word_of(a));
    end else begin
      chk(busy && !resp_valid, rq, "miss busy (R3)", {30'd0, busy, resp_valid}, 32'd2);
      for (int n = 0; n < 60; n++) begin
        @(negedge clk);
        #2;
        if (n == 0)
          chk(mem_req && mem_addr == a[AW-1:2], "R3", "block request", 32'(mem_addr), 32'(a[AW-1:2]));
        if (resp_valid) break;
        if (n == 59) chk(1'b0, "R4", "refill timeout", 32'd0, 32'd1);
      end
      chk(resp_valid && !resp_hit, "R4", "refill response flags", {30'd0, resp_valid, resp_hit}, 32'd2);
      chk(resp_data == word_of(a), "R4", "refill word", resp_data, word_of(a));
    end
  endtask

  task automatic t_reset;
    #2;
    chk(!busy && !resp_valid && !mem_req, "R1", "idle after reset",
        {29'd0, busy, resp_valid, mem_req}, 32'd0);
    access(adr(0, 1, 2), 1'b0, "R1");
  endtask

  task automatic t_words;
    access(adr(0, 1, 0), 1'b1, "R2");
    access(adr(0, 1, 3), 1'b1, "R2");
    access(adr(0, 1, 2), 1'b1, "R4");
  endtask

  task automatic t_fill_empty;
    for (int t = 2; t < 6; t++) begin
      lat = t - 2;
      access(adr(1, t, t & 3), 1'b0, "R5");
    end
    for (int t = 2; t < 6; t++) access(adr(1, t, 1), 1'b1, "R5");
  endtask

  task automatic t_mru_rounds;
    int keep;
    for (int t = 10; t < 14; t++) access(adr(2, t, 0), 1'b0, "R5");
    keep = 13;
    for (int r = 0; r < 24; r++) begin
      lat = r % 4;
      access(adr(2, keep, r & 3), 1'b1, "R6");
      access(adr(2, 40 + r, 1), 1'b0, "R6");
      access(adr(2, keep, 2), 1'b1, "R6");
      keep = 40 + r;
    end
  endtask

  task automatic t_sets_apart;
    for (int t = 2; t < 6; t++) access(adr(1, t, 3), 1'b1, "R7");
    access(adr(0, 1, 1), 1'b1, "R7");
  endtask

  task automatic t_back_to_back;
    logic [AW-1:0] a0, a1;
    a0 = adr(0, 1, 0);
    a1 = adr(1, 4, 3);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a0;
    @(negedge clk);
    req_addr = a1;
    #2;
    chk(resp_valid && resp_hit && !busy, "R8", "first hit, not busy",
        {29'd0, resp_valid, resp_hit, busy}, 32'd6);
    chk(resp_data == word_of(a0), "R8", "first word", resp_data, word_of(a0));
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    chk(resp_valid && resp_hit, "R8", "second hit", {30'd0, resp_valid, resp_hit}, 32'd3);
    chk(resp_data == word_of(a1), "R8", "second word", resp_data, word_of(a1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_words;
    t_fill_empty;
    t_mru_rounds;
    t_sets_apart;
    t_back_to_back;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (R1-scope run hung): actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule